// File: doc/BRIEF.md
# Phase-Accumulator Clock Pin

This block turns the system clock into a lower output frequency using a 32-bit phase accumulator. A programmable prescaler splits the system clock into base periods. At the end of each base period the accumulator takes a step of a programmable increment. The pin output is the top bit of the accumulator. The long-run output frequency is therefore `f_sys * incr / (2^32 * period)`.

Every output edge falls on a system-clock edge. When the ratio is not a whole number, successive output periods alternate between the two neighbouring whole clock counts. The average frequency is still correct. A sticky event flag records each wrap of the accumulator. The flag stays set until it is cleared. Dropping the enable returns the block to an idle, zeroed state.

Top module: `nco_pin`

## Requirements
- R1: While `en` is low, `pin_o` and `flag_o` are 0 and the accumulator is held at zero, so the first step after enabling yields exactly the increment.
- R2: With `period_i` = P ≥ 1, the accumulator steps once every P clocks. The first step lands on the P-th rising edge that samples `en` high.
- R3: A `period_i` of 0 behaves like 1: the accumulator steps on every clock.
- R4: `pin_o` equals bit 31 of the accumulator.
- R5: When an addition carries out of bit 31, `flag_o` becomes 1 on the same edge.
- R6: `flag_o` stays at 1 until `flag_clr` is sampled high. A clear on an edge with no carry drops it to 0.
- R7: If `flag_clr` is sampled high on the same edge as a carry, `flag_o` stays 1.
- R8: A change of `incr_i` while enabled is applied at the next step and does not reset the accumulator.
- R9: For a non-integer clock ratio, the gaps between rising edges of `pin_o` take only the two neighbouring whole clock counts. With P=1 and incr ≈ 0.3·2^32, the gaps are 3 and 4 clocks and there are about 3 rises per 10 clocks.
- R10: Lowering `en` in mid-run clears the pin, the flag and the accumulator on the next edge. Re-enabling restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low holds the block idle and zeroed |
| period_i | input | 16 | Base period in system clocks (0 means 1) |
| incr_i | input | 32 | Accumulator increment per base period |
| flag_clr | input | 1 | Clears the wrap flag |
| pin_o | output | 1 | Accumulator MSB, the generated clock |
| flag_o | output | 1 | Sticky accumulator wrap flag |

## Verification
The hardest case to reach is a clear that arrives on exactly the edge where the accumulator wraps. The bench sets P=1 and an increment of 2^31, so the accumulator wraps on every second clock. It then drives `flag_clr` in the cycle just before a known wrap edge, and again before a known non-wrap edge. A second hard case is proving that an increment change does not reset the phase. The bench picks old and new increments whose sum has the top bit set, while the new increment alone does not. The bench also records the clock gap between every pair of rising edges of `pin_o` over a long run, to confirm the dithering between 3 and 4 clocks.

// File: rtl/nco_pin.sv
module nco_pin #(
  parameter int PW = 16,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] period_i,
  input  logic [AW-1:0] incr_i,
  input  logic          flag_clr,
  output logic          pin_o,
  output logic          flag_o
);

  logic [PW-1:0] cnt;
  logic [AW-1:0] acc;
  logic          flag_q;
  logic [PW-1:0] per_eff;
  logic [AW:0]   sum;
  logic          step;
  logic          wrap;

  assign per_eff = (period_i == '0) ? PW'(1) : period_i;
  assign step    = en && (cnt >= per_eff - PW'(1));
  assign sum     = {1'b0, acc} + {1'b0, incr_i};
  assign wrap    = step && sum[AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || step) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (!en) begin
      acc <= '0;
    end else if (step) begin
      acc <= sum[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (!en) begin
      flag_q <= 1'b0;
    end else if (wrap) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign pin_o  = acc[AW-1];
  assign flag_o = flag_q;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pin_o && !flag_o && acc == '0)); // R1

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> (acc == $past(acc))); // R2

  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flag_o && !flag_clr) |=> flag_o); // R6

  AST_CLR_WINS_ON_NOWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flag_clr && !wrap) |=> !flag_o); // R6

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_o); // R7

  AST_RISE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(step)); // R5

endmodule

// File: tb/nco_pin_tb_top.sv
module nco_pin_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] period_i = 16'd1;
  logic [31:0] incr_i = '0;
  logic        flag_clr = 1'b0;
  logic        pin_o;
  logic        flag_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  nco_pin dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .period_i(period_i),
    .incr_i(incr_i), .flag_clr(flag_clr), .pin_o(pin_o), .flag_o(flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [15:0] p, input logic [31:0] inc);
    en = 1'b0;
    tick(1);
    period_i = p;
    incr_i = inc;
    en = 1'b1;
  endtask

  task automatic t_reset;
    chk(pin_o == 1'b0, "R1 pin in reset", int'(pin_o), 0);
    chk(flag_o == 1'b0, "R1 flag in reset", int'(flag_o), 0);
    rst_n = 1'b1;
    incr_i = 32'h8000_0000;
    tick(5);
    chk(pin_o == 1'b0 && flag_o == 1'b0, "R1 idle while disabled", int'({pin_o, flag_o}), 0);
  endtask

  task automatic t_msb;
    restart(16'd1, 32'h8000_0000);
    tick(1);
    chk(pin_o == 1'b1, "R1 first step equals increment", int'(pin_o), 1);
    tick(1);
    chk(pin_o == 1'b0, "R4 msb after wrap", int'(pin_o), 0);
    chk(flag_o == 1'b1, "R5 flag on carry", int'(flag_o), 1);
    restart(16'd1, 32'h4000_0000);
    tick(1);
    chk(pin_o == 1'b0, "R4 quarter", int'(pin_o), 0);
    tick(1);
    chk(pin_o == 1'b1, "R4 half", int'(pin_o), 1);
    tick(1);
    chk(pin_o == 1'b1 && flag_o == 1'b0, "R4 three quarters no flag", int'({pin_o, flag_o}), 2);
    tick(1);
    chk(pin_o == 1'b0 && flag_o == 1'b1, "R5 wrap", int'({pin_o, flag_o}), 1);
  endtask

  task automatic t_prescale;
    restart(16'd5, 32'h8000_0000);
    tick(4);
    chk(pin_o == 1'b0, "R2 no step before P edges", int'(pin_o), 0);
    tick(1);
    chk(pin_o == 1'b1, "R2 step at P-th edge", int'(pin_o), 1);
    tick(4);
    chk(pin_o == 1'b1 && flag_o == 1'b0, "R2 held within period", int'({pin_o, flag_o}), 2);
    tick(1);
    chk(pin_o == 1'b0 && flag_o == 1'b1, "R2 second step wraps", int'({pin_o, flag_o}), 1);
  endtask

  task automatic t_zero_period;
    restart(16'd0, 32'h8000_0000);
    tick(1);
    chk(pin_o == 1'b1, "R3 period 0 steps each clock", int'(pin_o), 1);
    tick(1);
    chk(pin_o == 1'b0 && flag_o == 1'b1, "R3 second clock wraps", int'({pin_o, flag_o}), 1);
  endtask

  task automatic t_sticky;
    incr_i = 32'h0;
    tick(10);
    chk(flag_o == 1'b1, "R6 flag sticky", int'(flag_o), 1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk(flag_o == 1'b0, "R6 clear drops flag", int'(flag_o), 0);
  endtask

  task automatic t_collide;
    restart(16'd1, 32'h8000_0000);
    tick(1);
    tick(1);
    chk(flag_o == 1'b1, "R7 setup flag", int'(flag_o), 1);
    tick(1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk(flag_o == 1'b1, "R7 clear with carry keeps flag", int'(flag_o), 1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk(flag_o == 1'b0, "R6 clear without carry", int'(flag_o), 0);
  endtask

  task automatic t_incr_change;
    restart(16'd4, 32'h6000_0000);
    tick(4);
    chk(pin_o == 1'b0, "R8 first step", int'(pin_o), 0);
    incr_i = 32'h2000_0000;
    tick(3);
    chk(pin_o == 1'b0, "R8 no change mid-period", int'(pin_o), 0);
    tick(1);
    chk(pin_o == 1'b1, "R8 new increment added to kept phase", int'(pin_o), 1);
  endtask

  task automatic t_dither;
    int rises = 0;
    int last = -1;
    int bad = 0;
    logic prev = 1'b0;
    restart(16'd1, 32'd1288490189);
    for (int i = 0; i < 1000; i++) begin
      tick(1);
      if (pin_o && !prev) begin
        if (last >= 0 && (i - last) != 3 && (i - last) != 4) bad++;
        last = i;
        rises++;
      end
      prev = pin_o;
    end
    chk(bad == 0, "R9 gaps only 3 or 4 clocks", bad, 0);
    chk(rises >= 299 && rises <= 301, "R9 average rate", rises, 300);
  endtask

  task automatic t_disable;
    restart(16'd1, 32'h4000_0000);
    tick(3);
    chk(pin_o == 1'b1, "R10 running", int'(pin_o), 1);
    en = 1'b0;
    tick(1);
    chk(pin_o == 1'b0 && flag_o == 1'b0, "R10 idle after drop", int'({pin_o, flag_o}), 0);
    incr_i = 32'h8000_0000;
    en = 1'b1;
    tick(1);
    chk(pin_o == 1'b1 && flag_o == 1'b0, "R10 restart from zero", int'({pin_o, flag_o}), 2);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    t_msb();
    t_prescale();
    t_zero_period();
    t_sticky();
    t_collide();
    t_incr_change();
    t_dither();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule